// File: doc/BRIEF.md
# Power-up reset hold timer

This block keeps a processor core in reset for a fixed number of slow timing ticks after the board-level reset line is released. The same hold is started again when the watchdog expires. The core therefore does not start running until the supply and the oscillator have had time to settle. The tick input is a one-cycle enable from a free-running low-speed timebase. The two hold lengths, LONG_TICKS and SHORT_TICKS, are parameters counted in those ticks.

Which length applies depends on the oscillator mode code and on a sticky first-boot flag. A power-on pulse sets the flag, and the first completed hold clears it. The two crystal-style modes always use the long hold. The two RC modes use the long hold only for the first hold after power-on, and the short hold for every later one. The core reset rises in the same cycle as any reset cause, because it is built combinationally from those causes. It falls only on a clock edge, when the final tick is counted.

Top module: `rst_hold_timer`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is high. After `por_i` falls, it stays high as long as the external release input stays low.
- R2: Ticks that arrive while `ext_rel_i` is low do not advance the hold. Counting starts only once `ext_rel_i` is high.
- R3: The first hold after a power-on pulse lasts LONG_TICKS ticks in any mode. `core_rst_o` falls at the clock edge that counts the LONG_TICKS-th tick taken with `ext_rel_i` high.
- R4: After the first hold has completed, a new hold in mode 2'b00 (internal RC) or 2'b01 (external RC) lasts SHORT_TICKS ticks.
- R5: In mode 2'b10 (crystal) or 2'b11 (low-frequency crystal), every hold lasts LONG_TICKS ticks, including holds after the first one.
- R6: A one-cycle `wdt_to_i` pulse raises `core_rst_o` in that same cycle. It restarts the hold from zero, with the length set by R3, R4 or R5.
- R7: If `ext_rel_i` falls while a hold is counting, the count is discarded. After `ext_rel_i` rises again, a full hold is needed.
- R8: `core_rst_o` goes high in the same cycle that `ext_rel_i` goes low, before the next clock edge.
- R9: `core_rst_o` falls only on a clock edge at which a tick was counted.
- R10: Cycles with `tick_i` low do not advance the hold.
- R11: A watchdog pulse during the first hold after power-on does not clear the first-boot flag. The restarted hold in an RC mode still lasts LONG_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset pulse, active high; also sets the first-boot flag |
| ext_rel_i | input | 1 | Synchronized external reset level; high means released |
| wdt_to_i | input | 1 | Watchdog time-out pulse, active high |
| osc_mode_i | input | 2 | Oscillator mode code: 00 internal RC, 01 external RC, 10 crystal, 11 low-frequency crystal |
| tick_i | input | 1 | One-cycle enable from the slow timebase |
| core_rst_o | output | 1 | Internal core reset, active high |

## Verification
The bench builds the timer with LONG_TICKS=12 and SHORT_TICKS=3, so that every hold finishes within a few dozen cycles. With these values one run can count each kind of hold tick by tick. The run covers the first-boot hold, the short later holds in both RC modes, the long later holds in both crystal modes, a watchdog restart during the first hold and an external reset that drops in the middle of a count. Because the two lengths differ by a factor of four, a hold of the wrong kind is caught at its exact release edge.

// File: rtl/rst_hold_pkg.sv
package rst_hold_pkg;

    typedef enum logic [1:0] {
        OSC_IRC  = 2'b00,
        OSC_ERC  = 2'b01,
        OSC_XTAL = 2'b10,
        OSC_LOWF = 2'b11
    } osc_mode_e;

    typedef enum logic {
        HOLD_FULL  = 1'b0,
        HOLD_SHORT = 1'b1
    } hold_kind_e;

    // Inputs that drive the counter in one cycle
    typedef struct packed {
        logic por;
        logic wdt;
        logic ext_low;
        logic tick;
    } hold_evt_t;

    // RC modes get the short hold once the first boot is over
    function automatic hold_kind_e pick_kind(osc_mode_e m, logic first_boot);
        if (!first_boot && (m == OSC_IRC || m == OSC_ERC))
            return HOLD_SHORT;
        return HOLD_FULL;
    endfunction

    function automatic logic evt_restart(hold_evt_t e);
        return e.por | e.wdt | e.ext_low;
    endfunction

endpackage

// File: rtl/rst_hold_len.sv
module rst_hold_len
    import rst_hold_pkg::*;
#(
    parameter int LONG_TICKS  = 576,
    parameter int SHORT_TICKS = 10,
    parameter int CNT_W       = 10
) (
    input  logic             clk_i,
    input  logic             por_i,
    input  logic             done_i,
    input  logic [1:0]       mode_i,
    output logic [CNT_W-1:0] limit_o
);

    logic       first_q;
    hold_kind_e kind;

    always_ff @(posedge clk_i) begin
        if (por_i)
            first_q <= 1'b1;
        else if (done_i)
            first_q <= 1'b0;
    end

    always_comb begin
        kind = pick_kind(osc_mode_e'(mode_i), first_q);
        if (kind == HOLD_SHORT)
            limit_o = CNT_W'(SHORT_TICKS);
        else
            limit_o = CNT_W'(LONG_TICKS);
    end

    AST_FIRST_SET: assert property (@(posedge clk_i)
        por_i |=> first_q);                                   // R11
    AST_FIRST_CLEAR: assert property (@(posedge clk_i) disable iff (por_i)
        done_i |=> !first_q);                                  // R4

endmodule

// File: rtl/rst_hold_cnt.sv
module rst_hold_cnt
    import rst_hold_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  hold_evt_t        evt_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             busy_o,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             restart;
    logic             last;

    assign restart = evt_restart(evt_i);
    assign last    = (cnt_q >= limit_i - CNT_W'(1));
    assign done_o  = busy_q & evt_i.tick & ~restart & last;
    assign busy_o  = busy_q;

    always_ff @(posedge clk_i) begin
        if (restart) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q && evt_i.tick) begin
            if (last) begin
                cnt_q  <= '0;
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_WDT_RESTART: assert property (@(posedge clk_i) disable iff (evt_i.por)
        evt_i.wdt |=> (busy_q && cnt_q == '0));               // R6
    AST_LOW_CLEARS: assert property (@(posedge clk_i) disable iff (evt_i.por)
        evt_i.ext_low |=> (busy_q && cnt_q == '0));           // R7
    AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (evt_i.por)
        (busy_q && !evt_i.tick && !restart) |=> ($stable(cnt_q) && busy_q)); // R10

endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer
    import rst_hold_pkg::*;
#(
    parameter int LONG_TICKS  = 576,
    parameter int SHORT_TICKS = 10
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       ext_rel_i,
    input  logic       wdt_to_i,
    input  logic [1:0] osc_mode_i,
    input  logic       tick_i,
    output logic       core_rst_o
);

    localparam int CNT_W = $clog2(LONG_TICKS + 1);

    hold_evt_t        evt;
    logic [CNT_W-1:0] limit;
    logic             busy;
    logic             done;

    always_comb begin
        evt.por     = por_i;
        evt.wdt     = wdt_to_i;
        evt.ext_low = ~ext_rel_i;
        evt.tick    = tick_i;
    end

    rst_hold_len #(
        .LONG_TICKS (LONG_TICKS),
        .SHORT_TICKS(SHORT_TICKS),
        .CNT_W      (CNT_W)
    ) u_len (
        .clk_i  (clk_i),
        .por_i  (por_i),
        .done_i (done),
        .mode_i (osc_mode_i),
        .limit_o(limit)
    );

    rst_hold_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk_i  (clk_i),
        .evt_i  (evt),
        .limit_i(limit),
        .busy_o (busy),
        .done_o (done)
    );

    // Any cause raises the reset at once; only the counter lowers it
    assign core_rst_o = busy | evt_restart(evt);

    AST_SYNC_RELEASE: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(core_rst_o) |-> $past(tick_i));                  // R9
    AST_POR_HOLDS: assert property (@(posedge clk_i)
        por_i |=> busy);                                        // R1

endmodule

// File: tb/rst_hold_timer_bench.sv
module rst_hold_timer_bench;

    localparam int CLK_P = 10;
    localparam int LONG  = 12;
    localparam int SHORT = 3;

    logic       clk = 1'b0;
    logic       por = 1'b0;
    logic       ext = 1'b0;
    logic       wdt = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       core_rst;

    int errors = 0;
    int checks = 0;
    int wd_cnt = 0;

    typedef struct {
        logic  exp;
        string req;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    rst_hold_timer #(
        .LONG_TICKS (LONG),
        .SHORT_TICKS(SHORT)
    ) u_rst_hold_timer (
        .clk_i     (clk),
        .por_i     (por),
        .ext_rel_i (ext),
        .wdt_to_i  (wdt),
        .osc_mode_i(mode),
        .tick_i    (tick),
        .core_rst_o(core_rst)
    );

    // Monitor: compare after each edge, away from it
    always @(posedge clk) begin
        #(CLK_P/4);
        while (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if (core_rst !== it.exp) begin
                errors++;
                $display("FAIL %s: core_rst=%0b expected %0b at %0t",
                         it.req, core_rst, it.exp, $time);
            end
        end
    end

    task automatic cyc(input logic p, input logic e, input logic w,
                       input logic t, input logic exp, input string req);
        exp_t it;
        @(negedge clk);
        por = p; ext = e; wdt = w; tick = t;
        @(posedge clk);
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic check_now(input logic exp, input string req);
        #1;
        checks++;
        if (core_rst !== exp) begin
            errors++;
            $display("FAIL %s: core_rst=%0b expected %0b (same cycle) at %0t",
                     req, core_rst, exp, $time);
        end
    endtask

    // Ticks with release high; reset must drop exactly on the n-th
    task automatic run_hold(input int n, input string req);
        for (int i = 1; i <= n; i++)
            cyc(1'b0, 1'b1, 1'b0, 1'b1, (i < n) ? 1'b1 : 1'b0, req);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, req);
    endtask

    task automatic ext_pulse_low(input string req);
        @(negedge clk);
        por = 1'b0; ext = 1'b0; wdt = 1'b0; tick = 1'b0;
        check_now(1'b1, "R8");
        @(posedge clk);
        begin
            exp_t it;
            it.exp = 1'b1;
            it.req = req;
            sb_q.push_back(it);
        end
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: power-on pulse
        mode = 2'b00;
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
        // R2: ticks while external reset low
        for (int i = 0; i < 2 * LONG; i++)
            cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
        // R10: release high, no ticks
        for (int i = 0; i < 4; i++)
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        // R3: first hold, long
        run_hold(LONG, "R3");

        // R4: later hold, internal RC
        ext_pulse_low("R4");
        run_hold(SHORT, "R4");
        // R4: external RC
        mode = 2'b01;
        ext_pulse_low("R4");
        run_hold(SHORT, "R4");

        // R5: crystal modes keep long hold
        mode = 2'b10;
        ext_pulse_low("R5");
        run_hold(LONG, "R5");
        mode = 2'b11;
        ext_pulse_low("R5");
        run_hold(LONG, "R5");

        // R6: watchdog restart in RC mode
        mode = 2'b00;
        @(negedge clk);
        por = 1'b0; ext = 1'b1; wdt = 1'b1; tick = 1'b0;
        check_now(1'b1, "R6");
        @(posedge clk);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        run_hold(SHORT, "R6");

        // R7: external reset dropping mid-count
        mode = 2'b10;
        ext_pulse_low("R7");
        for (int i = 0; i < LONG - 2; i++)
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7");
        ext_pulse_low("R7");
        run_hold(LONG, "R7");

        // R11: watchdog during first hold keeps long length
        mode = 2'b00;
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        for (int i = 0; i < 4; i++)
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R11");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R11");
        run_hold(LONG, "R11");
        // afterwards the short hold applies again
        ext_pulse_low("R4");
        run_hold(SHORT, "R4");

        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule